// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the word addresses of a four-word burst for a synchronous memory. A base address is captured when either of two active-low load strobes is low at a rising clock edge. One strobe is meant for a processor and the other for a memory controller. After the capture, a two-bit beat counter starts at zero and steps on each edge where the active-low advance input is low. The low two address bits are formed from the captured start bits and the counter. The bits above them stay as captured for the whole burst.

The ordering input is not registered and takes effect at once. When it is low, the low bits run linearly: start, start+1, start+2, start+3, wrapping modulo four. When it is high, the low bits are the start bits XORed with the beat count, which gives the interleaved order. A wrap flag reports that the fourth advance has brought the burst back to its starting word.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and after its release until the first load, addr_o is all zeros and wrap_o is 0.
- R2: When ld_proc_n is 0 at a rising edge, addr_o equals the base_addr value sampled at that edge after the edge, and the beat count restarts at 0.
- R3: When ld_ctrl_n is 0 at a rising edge, the same capture as R2 takes place, whatever the state of ld_proc_n.
- R4: The beat count steps by one (modulo 4) only on an edge where adv_n is 0 and neither strobe is 0.
- R5: With order_ilv = 0 (linear), addr_o[1:0] equals (start + count) mod 4, where start is the captured base_addr[1:0].
- R6: With order_ilv = 1 (interleaved), addr_o[1:0] equals start XOR count.
- R7: addr_o[ADDR_W-1:2] changes only on an edge with a load; advances never alter it.
- R8: The advance that takes the count from 3 back to 0 sets wrap_o to 1, and addr_o then equals the captured base again. wrap_o stays 1 through hold cycles and is cleared by the next advance or load.
- R9: A load takes priority over an advance on the same edge: the count becomes 0 and wrap_o becomes 0.
- R10: On an edge with no load and adv_n = 1, the count and wrap_o hold, and addr_o keeps its value while order_ilv is steady.
- R11: A change of order_ilv takes effect on addr_o combinationally, without a clock edge, and leaves the beat count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_proc_n | input | 1 | Active-low load strobe, processor side |
| ld_ctrl_n | input | 1 | Active-low load strobe, controller side |
| adv_n | input | 1 | Active-low burst advance |
| order_ilv | input | 1 | Ordering: 0 linear, 1 interleaved (not registered) |
| base_addr | input | ADDR_W | Start address captured on a load |
| addr_o | output | ADDR_W | Current burst word address |
| wrap_o | output | 1 | Burst has returned to its start word |

## Verification
The bench builds the sequencer with ADDR_W = 6. The burst logic only acts on the two low bits, so this width loses nothing. With a four-bit upper field the bench can give every burst its own upper value, and a stray change of the upper bits then shows up. The sweep covers every start value, both orderings and both strobes, and follows each burst through a full wrap plus a hold cycle. Further sequences cover a load and an advance on the same edge, and a change of ordering in the middle of a burst.

// File: rtl/bas_pkg.sv
package bas_pkg;

  localparam int unsigned BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Low-address word for one beat of a burst.
  function automatic beat_t beat_word(input beat_t start, input beat_t cnt,
                                      input order_e ord);
    beat_t w;
    if (ord == ORD_INTERLEAVE) w = start ^ cnt;
    else                       w = start + cnt;
    return w;
  endfunction

endpackage

// File: rtl/bas_base_reg.sv
module bas_base_reg #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned LOW_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic [ADDR_W-1:0]       base_in,
  output logic [ADDR_W-LOW_W-1:0] upper_q,
  output logic [LOW_W-1:0]        start_q
);

  localparam int unsigned UP_W = ADDR_W - LOW_W;

  logic [UP_W-1:0]  upper_d;
  logic [LOW_W-1:0] start_d;

  // next state: capture on load, otherwise keep
  always_comb begin
    upper_d = upper_q;
    start_d = start_q;
    if (load_en) begin
      upper_d = base_in[ADDR_W-1:LOW_W];
      start_d = base_in[LOW_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
    end else begin
      upper_q <= upper_d;
      start_q <= start_d;
    end
  end

endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  logic  step_en,
  output beat_t cnt_q,
  output logic  wrap_q
);

  localparam beat_t LAST_BEAT = '1;

  beat_t cnt_d;
  logic  wrap_d;

  // load clears and wins over a step; idle holds both
  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    if (load_en) begin
      cnt_d  = '0;
      wrap_d = 1'b0;
    end else if (step_en) begin
      cnt_d  = cnt_q + beat_t'(1);
      wrap_d = (cnt_q == LAST_BEAT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
(
  input  beat_t start_i,
  input  beat_t cnt_i,
  input  logic  order_i,
  output beat_t word_o
);

  order_e ord;

  always_comb begin
    ord    = order_e'(order_i);
    word_o = beat_word(start_i, cnt_i, ord);
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_proc_n,
  input  logic              ld_ctrl_n,
  input  logic              adv_n,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wrap_o
);

  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic            load_en;
  logic            step_en;
  logic [UP_W-1:0] upper_q;
  beat_t           start_q;
  beat_t           burst_cnt;
  beat_t           low_word;

  always_comb begin
    load_en = !ld_proc_n || !ld_ctrl_n;
    step_en = !adv_n;
  end

  bas_base_reg #(
    .ADDR_W (ADDR_W),
    .LOW_W  (BEAT_W)
  ) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .base_in (base_addr),
    .upper_q (upper_q),
    .start_q (start_q)
  );

  bas_beat_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .step_en (step_en),
    .cnt_q   (burst_cnt),
    .wrap_q  (wrap_o)
  );

  bas_order_map u_map (
    .start_i (start_q),
    .cnt_i   (burst_cnt),
    .order_i (order_ilv),
    .word_o  (low_word)
  );

  always_comb addr_o = {upper_q, low_word};

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_proc_n,
  input logic              ld_ctrl_n,
  input logic              adv_n,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] addr_o,
  input logic              wrap_o,
  input logic [1:0]        burst_cnt
);

  logic ld_any;
  always_comb ld_any = !ld_proc_n || !ld_ctrl_n;

  p_proc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_proc_n |=> (addr_o == $past(base_addr)) && (burst_cnt == 2'd0));

  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ctrl_n |=> addr_o == $past(base_addr));

  p_step_only_on_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_any && !adv_n) |=> burst_cnt == $past(burst_cnt) + 2'd1);

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_any |=> $stable(addr_o[ADDR_W-1:2]));

  p_wrap_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_any && !adv_n && burst_cnt == 2'd3) |=> wrap_o);

  p_load_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_any && !adv_n) |=> (!wrap_o && burst_cnt == 2'd0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_any && adv_n) |=> ($stable(burst_cnt) && $stable(wrap_o)
                            && ($stable(addr_o) || !$stable(order_ilv))));

endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_proc_n (ld_proc_n),
  .ld_ctrl_n (ld_ctrl_n),
  .adv_n     (adv_n),
  .order_ilv (order_ilv),
  .base_addr (base_addr),
  .addr_o    (addr_o),
  .wrap_o    (wrap_o),
  .burst_cnt (burst_cnt)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

  localparam int unsigned AW = 6;

  logic          clk;
  logic          rst_n;
  logic          ld_proc_n;
  logic          ld_ctrl_n;
  logic          adv_n;
  logic          order_ilv;
  logic [AW-1:0] base_addr;
  logic [AW-1:0] addr_o;
  logic          wrap_o;

  int checks;
  int errors;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_proc_n (ld_proc_n),
    .ld_ctrl_n (ld_ctrl_n),
    .adv_n     (adv_n),
    .order_ilv (order_ilv),
    .base_addr (base_addr),
    .addr_o    (addr_o),
    .wrap_o    (wrap_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [1:0] exp_low(input logic [1:0] s, input int k,
                                         input logic ilv);
    logic [1:0] c;
    c = 2'(k);
    return ilv ? (s ^ c) : (s + c);
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] exp_a,
                     input logic exp_w);
    checks++;
    if (addr_o !== exp_a || wrap_o !== exp_w) begin
      errors++;
      $display("FAIL %s: actual addr=%0h wrap=%0b expected addr=%0h wrap=%0b",
               req, addr_o, wrap_o, exp_a, exp_w);
    end
  endtask

  // drive at falling edge, let one rising edge pass, return at falling edge
  task automatic cyc(input logic lp, input logic lc, input logic av,
                     input logic [AW-1:0] b);
    ld_proc_n = lp; ld_ctrl_n = lc; adv_n = av; base_addr = b;
    @(posedge clk);
    @(negedge clk);
    ld_proc_n = 1'b1; ld_ctrl_n = 1'b1; adv_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] b;
    logic [AW-1:0] e;
    checks = 0; errors = 0;
    rst_n = 1'b0; ld_proc_n = 1'b1; ld_ctrl_n = 1'b1; adv_n = 1'b1;
    order_ilv = 1'b0; base_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", '0, 1'b0);
    rst_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, 6'h3f);
    chk("R1 after release", '0, 1'b0);

    // sweep strobe x ordering x start
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int lo = 0; lo < 4; lo++) begin
          b = {4'(s * 8 + m * 4 + lo + 1), 2'(lo)};
          order_ilv = m[0];
          if (s == 0) cyc(1'b0, 1'b1, 1'b1, b);
          else        cyc(1'b1, 1'b0, 1'b1, b);
          chk(s == 0 ? "R2 proc load" : "R3 ctrl load", b, 1'b0);
          for (int k = 1; k <= 4; k++) begin
            cyc(1'b1, 1'b1, 1'b0, ~b);
            e = {b[AW-1:2], exp_low(b[1:0], k, m[0])};
            // R4 R5 R6 R7 R8
            chk(m == 0 ? "R5/R7/R8 linear step" : "R6/R7/R8 interleaved step",
                e, k == 4);
          end
          cyc(1'b1, 1'b1, 1'b1, ~b);
          chk("R10/R8 hold keeps address and wrap", b, 1'b1);
          cyc(1'b1, 1'b1, 1'b0, ~b);
          e = {b[AW-1:2], exp_low(b[1:0], 1, m[0])};
          chk("R8 advance clears wrap", e, 1'b0);
        end
      end
    end

    // R3 ctrl strobe wins regardless of proc strobe
    order_ilv = 1'b0;
    cyc(1'b0, 1'b0, 1'b1, 6'h2d);
    chk("R3 both strobes", 6'h2d, 1'b0);

    // R9 load with advance on same edge, after a wrap
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 1'b0, 6'h00);
    chk("R8 wrap before priority test", 6'h2d, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 6'h16);
    chk("R9 load beats advance", 6'h16, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 6'h39);
    chk("R9 ctrl load beats advance", 6'h39, 1'b0);

    // R4 several idle cycles leave count untouched
    cyc(1'b1, 1'b1, 1'b0, 6'h00);
    repeat (3) cyc(1'b1, 1'b1, 1'b1, 6'h00);
    chk("R4/R10 no step without advance", 6'h3a, 1'b0);

    // R11 ordering change mid-burst: start 1, count 1
    cyc(1'b0, 1'b1, 1'b1, 6'h25);
    cyc(1'b1, 1'b1, 1'b0, 6'h00);
    chk("R11 linear before switch", 6'h26, 1'b0);
    order_ilv = 1'b1;
    #1;
    chk("R11 interleaved without edge", 6'h24, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 6'h00);
    chk("R11 count kept across switch", 6'h27, 1'b0);
    order_ilv = 1'b0;
    #1;
    chk("R11 back to linear", 6'h27, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule